// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Controller

This block is a synthesizable behavioural model of a byte-wide NOR flash with a bottom-boot sector layout. A host drives chip select, write strobe and read strobe as active-low levels sampled on the clock, with a 19-bit address and 8-bit write and read data. A cycle with select and write strobe low is a bus write. A cycle with select and read strobe low and write strobe high is a bus read. Multi-write unlock sequences start programming, chip erase or sector erase. A fast-program mode cuts each later byte program to two writes. The host polls completion either through the `ready` output or through status bits returned on reads while an operation runs.

The array keeps a window of `2**OFF_W` bytes per sector. The offset inside a sector is `addr[OFF_W-1:0]`, and all addresses in a sector with the same low bits share one byte. The sector is decoded from the full address: sector 0 covers 0x00000–0x03FFF, sector 1 0x04000–0x05FFF, sector 2 0x06000–0x07FFF, sector 3 0x08000–0x0FFFF, and sectors 4..10 are the 64 KB blocks from 0x10000 upward. Erase runs on each selected sector in turn. It first clears every byte to 0x00, then waits a shortened erase time, then sets the whole window to 0xFF. A second reset input aborts any operation without touching the array.

Top module: `nor_cmd_flash`

## Requirements
- R1: After `rst_n` low, `ready` is 1, every byte reads 0xFF, and `dout` is 0x00 in any cycle that is not a bus read.
- R2: The four writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, data@address (only the low 11 address bits are compared for unlock addresses) start a program. `ready` is low for exactly `PROG_CYC` clock edges after the data write, and the byte then reads back.
- R3: Programming can only clear bits: the stored byte becomes old AND new.
- R4: While `ready` is low, a read returns status: bit 7 is the inverse of bit 7 of the byte being programmed (0 during erase), bit 6 inverts on every such read, and bits 5..0 are 0. True data returns once `ready` is high.
- R5: Writing 0x20 as the third unlock cycle enters fast-program mode, in which 0xA0 at any address followed by data@address programs. Writing 0xF0 in that mode leaves it, after which the two-write form has no effect.
- R6: A write that breaks an unlock or command sequence returns the decoder to read mode and changes no byte.
- R7: The sequence AA/55/0x80/AA/55 followed by 0x30 at a sector address erases that sector to 0xFF and leaves neighbouring sectors intact. Status bit 7 reads 0 during the erase.
- R8: Within `ACCEPT_CYC` cycles of the last 0x30 write, a further 0x30 write adds the addressed sector to the erase.
- R9: The same prefix followed by 0x10@0x555 erases every unprotected sector.
- R10: A sector whose `prot` bit is 1 is unchanged by program and erase. An operation on only protected sectors still ends with `ready` high.
- R11: 0xB0 written during erase suspends it with `ready` high after the next edge. Reads of sectors still pending erase return 0x80, other sectors read and program normally, and 0x30 resumes the erase to completion.
- R12: `hw_rst_n` low aborts any operation. `ready` is high after that edge, the decoder is back in read mode, and bytes outside an aborted erase keep their values.
- R13: Sector boundaries follow the bottom-boot map above: erasing sector 1 leaves 0x03FFF and 0x06000 untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also fills the array with 0xFF |
| hw_rst_n | input | 1 | Synchronous active-low abort to read mode; array kept |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | 19 | Byte address |
| din | input | 8 | Write data or command byte |
| prot | input | 11 | Per-sector protection, bit i guards sector i |
| dout | output | 8 | Read data or status; 0x00 outside read cycles |
| dout_en | output | 1 | High during a bus read cycle |
| ready | output | 1 | 1 when no operation is running (suspended counts as ready) |

## Verification
A write is decoded at the edge where it is sampled. Any operation it starts pulls `ready` low at that same edge, so the bench checks `ready` at the falling edge right after the write. Read data is combinational from state, so each read is sampled 1 ns after the read strobe is driven in the low clock phase. The status toggle advances at the edge that ends the read. For programming, the bench counts falling edges until `ready` returns and expects exactly `PROG_CYC`. Suspend must show `ready` high one edge after the 0xB0 write, and an abort must show it one edge after the reset pulse. Erase lengths depend on the sector scan, so the bench waits on `ready` with a bound and then checks data.

// File: rtl/nfc_pkg.sv
// Shared constants, command codes and state types for the NOR flash model.
// Assumes the fixed bottom-boot layout of eleven sectors over a 19-bit space.
package nfc_pkg;
    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;
    localparam int NSEC   = 11;
    localparam int SEC_W  = 4;

    localparam logic [DATA_W-1:0] CMD_KEY1   = 8'hAA;
    localparam logic [DATA_W-1:0] CMD_KEY2   = 8'h55;
    localparam logic [DATA_W-1:0] CMD_PROG   = 8'hA0;
    localparam logic [DATA_W-1:0] CMD_ERASE  = 8'h80;
    localparam logic [DATA_W-1:0] CMD_CHIP   = 8'h10;
    localparam logic [DATA_W-1:0] CMD_SECT   = 8'h30;
    localparam logic [DATA_W-1:0] CMD_FAST   = 8'h20;
    localparam logic [DATA_W-1:0] CMD_SUSP   = 8'hB0;
    localparam logic [DATA_W-1:0] CMD_EXIT   = 8'hF0;

    typedef enum logic [3:0] {
        D_READ, D_KEY1, D_KEY2, D_PDATA, D_ERA1, D_ERA2, D_ERA3, D_FAST, D_FDATA
    } dec_st_t;

    typedef enum logic [2:0] {
        E_IDLE, E_PROG, E_WIN, E_SCAN, E_PRE, E_ERS, E_SUSP
    } eng_st_t;

    // Lowest address of sector idx; idx == NSEC gives the end of the space.
    function automatic logic [ADDR_W:0] sec_base(input int idx);
        logic [ADDR_W:0] b;
        case (idx)
            0:       b = 20'h00000;
            1:       b = 20'h04000;
            2:       b = 20'h06000;
            3:       b = 20'h08000;
            default: b = (ADDR_W+1)'(idx - 3) << 16;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/nfc_sector_map.sv
// Maps a byte address to its sector index using the bottom-boot layout.
// Assumes the package base table covers the whole address space.
module nfc_sector_map
    import nfc_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int NS   = NSEC,
    parameter int SW   = SEC_W
) (
    input  logic [AW-1:0] addr,
    output logic [SW-1:0] sec_idx
);
    localparam int EXT_W = AW + 1;

    logic [NS-1:0]    hit;
    logic [EXT_W-1:0] addr_ext;

    assign addr_ext = {1'b0, addr};

    // One range comparator per sector.
    for (genvar i = 0; i < NS; i++) begin : g_range
        assign hit[i] = (addr_ext >= EXT_W'(sec_base(i))) &&
                        (addr_ext <  EXT_W'(sec_base(i + 1)));
    end

    // Encode the one-hot hit vector into an index.
    always_comb begin
        sec_idx = '0;
        for (int i = 0; i < NS; i++) begin
            if (hit[i]) sec_idx = SW'(i);
        end
    end
endmodule

// File: rtl/nfc_cmd_decode.sv
// Bus-write command decoder: follows unlock sequences and emits one-cycle
// start, suspend and resume requests to the engine.
// Assumes writes while the engine runs are ignored except 0xB0 in erase and
// 0x30 inside the sector-accept window.
module nfc_cmd_decode
    import nfc_pkg::*;
#(
    parameter int UNL_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_rst_n,
    input  logic              wr,
    input  logic [UNL_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] din,
    input  logic              eng_accept,
    input  logic              eng_susp,
    input  logic              eng_win,
    input  logic              eng_erasing,
    output logic              go_prog,
    output logic              go_chip,
    output logic              go_sect,
    output logic              go_susp,
    output logic              go_res
);
    localparam logic [UNL_W-1:0] A_555 = UNL_W'(12'h555);
    localparam logic [UNL_W-1:0] A_2AA = UNL_W'(12'h2AA);

    dec_st_t st, nxt;
    logic    at_555, at_2aa;

    assign at_555 = (addr_lo == A_555);
    assign at_2aa = (addr_lo == A_2AA);

    // Next-state and request decode for one bus write.
    always_comb begin
        nxt     = st;
        go_prog = 1'b0;
        go_chip = 1'b0;
        go_sect = 1'b0;
        go_susp = 1'b0;
        go_res  = 1'b0;
        if (wr) begin
            if (eng_win) begin
                go_sect = (din == CMD_SECT);
            end else if (eng_erasing) begin
                go_susp = (din == CMD_SUSP);
            end else if (eng_accept) begin
                case (st)
                    D_READ: begin
                        if (at_555 && din == CMD_KEY1) nxt = D_KEY1;
                        else go_res = eng_susp && (din == CMD_SECT);
                    end
                    D_KEY1: nxt = (at_2aa && din == CMD_KEY2) ? D_KEY2 : D_READ;
                    D_KEY2: begin
                        if (at_555 && din == CMD_PROG)                    nxt = D_PDATA;
                        else if (at_555 && din == CMD_ERASE && !eng_susp) nxt = D_ERA1;
                        else if (at_555 && din == CMD_FAST && !eng_susp)  nxt = D_FAST;
                        else                                              nxt = D_READ;
                    end
                    D_PDATA: begin
                        go_prog = 1'b1;
                        nxt     = D_READ;
                    end
                    D_ERA1: nxt = (at_555 && din == CMD_KEY1) ? D_ERA2 : D_READ;
                    D_ERA2: nxt = (at_2aa && din == CMD_KEY2) ? D_ERA3 : D_READ;
                    D_ERA3: begin
                        go_chip = at_555 && (din == CMD_CHIP);
                        go_sect = (din == CMD_SECT);
                        nxt     = D_READ;
                    end
                    D_FAST: nxt = (din == CMD_PROG) ? D_FDATA : D_READ;
                    D_FDATA: begin
                        go_prog = 1'b1;
                        nxt     = D_FAST;
                    end
                    default: nxt = D_READ;
                endcase
            end
        end
    end

    // Sequence state register; both resets return to read mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !hw_rst_n) st <= D_READ;
        else                     st <= nxt;
    end
endmodule

// File: rtl/nfc_engine.sv
// Program/erase engine with the sector-window array and the read mux.
// Assumes requests arrive as one-cycle pulses already qualified by the
// decoder, and that prot is stable while an operation runs.
module nfc_engine
    import nfc_pkg::*;
#(
    parameter int NS         = NSEC,
    parameter int SW         = SEC_W,
    parameter int OFF_W      = 4,
    parameter int PROG_CYC   = 8,
    parameter int ERASE_CYC  = 16,
    parameter int ACCEPT_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_rst_n,
    input  logic              go_prog,
    input  logic              go_chip,
    input  logic              go_sect,
    input  logic              go_susp,
    input  logic              go_res,
    input  logic              rd,
    input  logic [SW-1:0]     sec_idx,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] din,
    input  logic [NS-1:0]     prot,
    output logic [DATA_W-1:0] dout,
    output logic              ready,
    output logic              accept,
    output logic              susp,
    output logic              win,
    output logic              erasing
);
    localparam int WIN   = 1 << OFF_W;
    localparam int DEPTH = NS * WIN;
    localparam int PCW   = $clog2(PROG_CYC + 1);
    localparam int ECW   = $clog2(ERASE_CYC + 1);
    localparam int WCW   = $clog2(ACCEPT_CYC + 1);

    eng_st_t           st, res_st;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [NS-1:0]     sel;
    logic [SW-1:0]     cur, p_sec;
    logic [OFF_W-1:0]  bidx, p_off;
    logic [DATA_W-1:0] p_dat;
    logic              p_blk, p_from_susp, tog;
    logic [PCW-1:0]    pcnt;
    logic [ECW-1:0]    ecnt;
    logic [WCW-1:0]    wcnt;
    logic              busy;

    assign busy    = (st == E_PROG) || (st == E_WIN) || erasing;
    assign erasing = (st == E_SCAN) || (st == E_PRE) || (st == E_ERS);
    assign ready   = !busy;
    assign accept  = (st == E_IDLE) || (st == E_SUSP);
    assign susp    = (st == E_SUSP);
    assign win     = (st == E_WIN);

    // Operation sequencing, array updates and status toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= E_IDLE;
            res_st      <= E_IDLE;
            sel         <= '0;
            cur         <= '0;
            bidx        <= '0;
            p_sec       <= '0;
            p_off       <= '0;
            p_dat       <= '0;
            p_blk       <= 1'b0;
            p_from_susp <= 1'b0;
            tog         <= 1'b0;
            pcnt        <= '0;
            ecnt        <= '0;
            wcnt        <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (!hw_rst_n) begin
            st          <= E_IDLE;
            sel         <= '0;
            p_from_susp <= 1'b0;
            tog         <= 1'b0;
        end else begin
            if (rd && busy) tog <= ~tog;
            case (st)
                E_IDLE, E_SUSP: begin
                    if (go_prog) begin
                        p_sec       <= sec_idx;
                        p_off       <= off;
                        p_dat       <= din;
                        p_blk       <= prot[sec_idx] || (st == E_SUSP && sel[sec_idx]);
                        p_from_susp <= (st == E_SUSP);
                        pcnt        <= PCW'(PROG_CYC);
                        st          <= E_PROG;
                    end else if (st == E_IDLE && go_chip) begin
                        sel <= '1;
                        cur <= '0;
                        st  <= E_SCAN;
                    end else if (st == E_IDLE && go_sect) begin
                        sel          <= '0;
                        sel[sec_idx] <= 1'b1;
                        wcnt         <= WCW'(ACCEPT_CYC);
                        st           <= E_WIN;
                    end else if (st == E_SUSP && go_res) begin
                        st <= res_st;
                    end
                end
                E_PROG: begin
                    if (pcnt == PCW'(1)) begin
                        if (!p_blk) mem[{p_sec, p_off}] <= mem[{p_sec, p_off}] & p_dat;
                        st <= p_from_susp ? E_SUSP : E_IDLE;
                    end else begin
                        pcnt <= pcnt - PCW'(1);
                    end
                end
                E_WIN: begin
                    if (go_sect) begin
                        sel[sec_idx] <= 1'b1;
                        wcnt         <= WCW'(ACCEPT_CYC);
                    end else if (wcnt == WCW'(1)) begin
                        cur <= '0;
                        st  <= E_SCAN;
                    end else begin
                        wcnt <= wcnt - WCW'(1);
                    end
                end
                E_SCAN, E_PRE, E_ERS: begin
                    if (go_susp) begin
                        res_st <= st;
                        st     <= E_SUSP;
                    end else if (st == E_SCAN) begin
                        if (sel[cur] && !prot[cur]) begin
                            bidx <= '0;
                            st   <= E_PRE;
                        end else begin
                            sel[cur] <= 1'b0;
                            if (cur == SW'(NS - 1)) st <= E_IDLE;
                            else                    cur <= cur + SW'(1);
                        end
                    end else if (st == E_PRE) begin
                        mem[{cur, bidx}] <= '0;
                        if (bidx == OFF_W'(WIN - 1)) begin
                            ecnt <= ECW'(ERASE_CYC);
                            st   <= E_ERS;
                        end else begin
                            bidx <= bidx + OFF_W'(1);
                        end
                    end else begin
                        if (ecnt == ECW'(1)) begin
                            for (int j = 0; j < WIN; j++) mem[{cur, OFF_W'(j)}] <= '1;
                            sel[cur] <= 1'b0;
                            if (cur == SW'(NS - 1)) begin
                                st <= E_IDLE;
                            end else begin
                                cur <= cur + SW'(1);
                                st  <= E_SCAN;
                            end
                        end else begin
                            ecnt <= ecnt - ECW'(1);
                        end
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    // Read mux: status while busy, marker for pending sectors when suspended.
    always_comb begin
        if (!rd)                        dout = '0;
        else if (busy)                  dout = {(st == E_PROG) ? ~p_dat[7] : 1'b0, tog, 6'b0};
        else if (susp && sel[sec_idx])  dout = 8'h80;
        else                            dout = mem[{sec_idx, off}];
    end
endmodule

// File: rtl/nor_cmd_flash.sv
// Top level: bus strobe decode, sector mapping, command decoder and engine.
// Assumes strobes are synchronous to clk and held for whole cycles.
module nor_cmd_flash
    import nfc_pkg::*;
#(
    parameter int OFF_W      = 4,
    parameter int PROG_CYC   = 8,
    parameter int ERASE_CYC  = 16,
    parameter int ACCEPT_CYC = 8,
    parameter int UNL_W      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [NSEC-1:0]   prot,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              ready
);
    logic             wr, rd;
    logic [SEC_W-1:0] sec_idx;
    logic             go_prog, go_chip, go_sect, go_susp, go_res;
    logic             accept, susp, win, erasing;

    assign wr      = !ce_n && !we_n;
    assign rd      = !ce_n && !oe_n && we_n;
    assign dout_en = rd;

    nfc_sector_map #(.AW(ADDR_W), .NS(NSEC), .SW(SEC_W)) u_map (
        .addr    (addr),
        .sec_idx (sec_idx)
    );

    nfc_cmd_decode #(.UNL_W(UNL_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_rst_n    (hw_rst_n),
        .wr          (wr),
        .addr_lo     (addr[UNL_W-1:0]),
        .din         (din),
        .eng_accept  (accept),
        .eng_susp    (susp),
        .eng_win     (win),
        .eng_erasing (erasing),
        .go_prog     (go_prog),
        .go_chip     (go_chip),
        .go_sect     (go_sect),
        .go_susp     (go_susp),
        .go_res      (go_res)
    );

    nfc_engine #(
        .NS(NSEC), .SW(SEC_W), .OFF_W(OFF_W), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .ACCEPT_CYC(ACCEPT_CYC)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_rst_n (hw_rst_n),
        .go_prog  (go_prog),
        .go_chip  (go_chip),
        .go_sect  (go_sect),
        .go_susp  (go_susp),
        .go_res   (go_res),
        .rd       (rd),
        .sec_idx  (sec_idx),
        .off      (addr[OFF_W-1:0]),
        .din      (din),
        .prot     (prot),
        .dout     (dout),
        .ready    (ready),
        .accept   (accept),
        .susp     (susp),
        .win      (win),
        .erasing  (erasing)
    );
endmodule

// File: rtl/nfc_checker.sv
// Property checker for nor_cmd_flash, attached with bind below.
// Assumes it sees the top-level strobes and the decoder's suspend request.
module nfc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_rst_n,
    input logic       rd,
    input logic       ready,
    input logic [7:0] dout,
    input logic       go_susp
);
    logic armed;

    // Marks cycles that have a full post-reset history behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> dout == 8'h00);

    a_r4_status_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ready) |-> dout[5:0] == 6'b0);

    a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rd && !ready && $past(rd && !ready) && $past(hw_rst_n))
            |-> dout[6] != $past(dout[6]));

    a_r11_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
        go_susp |=> ready);

    a_r12_abort_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |=> ready);
endmodule

bind nor_cmd_flash nfc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_rst_n (hw_rst_n),
    .rd       (rd),
    .ready    (ready),
    .dout     (dout),
    .go_susp  (go_susp)
);

// File: tb/nor_cmd_flash_bench.sv
`timescale 1ns/100ps
module nor_cmd_flash_bench;
    localparam int PROG_CYC   = 8;
    localparam int ERASE_CYC  = 16;
    localparam int ACCEPT_CYC = 8;
    localparam int OFF_W      = 4;
    localparam int WAIT_MAX   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, hw_rst_n = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [18:0] addr = '0;
    logic [7:0]  din = '0;
    logic [10:0] prot = '0;
    logic [7:0]  dout;
    logic        dout_en, ready;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nor_cmd_flash #(
        .OFF_W(OFF_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .ACCEPT_CYC(ACCEPT_CYC)
    ) u_nor_cmd_flash (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .prot(prot), .dout(dout),
        .dout_en(dout_en), .ready(ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [18:0] a, output logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1 d = dout;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < WAIT_MAX) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic unlock();
        bus_wr(19'h00555, 8'hAA);
        bus_wr(19'h002AA, 8'h55);
    endtask

    task automatic prog(input logic [18:0] a, input logic [7:0] d);
        unlock();
        bus_wr(19'h00555, 8'hA0);
        bus_wr(a, d);
    endtask

    task automatic erase_seq(input logic [18:0] a, input logic [7:0] last);
        unlock();
        bus_wr(19'h00555, 8'h80);
        unlock();
        bus_wr(a, last);
    endtask

    task automatic expect_byte(input logic [18:0] a, input logic [7:0] e, input string tag);
        logic [7:0] v;
        bus_rd(a, v);
        check(v == e, tag, v, e);
    endtask

    task automatic t_reset();
        check(ready == 1'b1, "R1 ready after reset", ready, 1);
        check(dout == 8'h00, "R1 dout idle", dout, 0);
        expect_byte(19'h00000, 8'hFF, "R1 erased low");
        expect_byte(19'h7FFFF, 8'hFF, "R1 erased high");
    endtask

    task automatic t_program();
        int n;
        prog(19'h00012, 8'h5A);
        check(ready == 1'b0, "R2 busy after data write", ready, 0);
        wait_ready(n);
        check(n == PROG_CYC, "R2 program length", n, PROG_CYC);
        expect_byte(19'h00012, 8'h5A, "R2 program data");
    endtask

    task automatic t_status();
        logic [7:0] s1, s2;
        int n;
        prog(19'h10003, 8'h3C);
        bus_rd(19'h10003, s1);
        bus_rd(19'h10003, s2);
        check(s1[7] == 1'b1, "R4 inverted bit 7", s1[7], 1);
        check(s1[5:0] == 6'b0, "R4 low status bits", s1[5:0], 0);
        check(s2[6] != s1[6], "R4 toggle bit", s2[6], ~s1[6]);
        wait_ready(n);
        expect_byte(19'h10003, 8'h3C, "R4 true data after");
    endtask

    task automatic t_and();
        int n;
        prog(19'h00012, 8'hF0);
        wait_ready(n);
        expect_byte(19'h00012, 8'h50, "R3 bits only clear");
    endtask

    task automatic t_fast();
        int n;
        unlock();
        bus_wr(19'h00555, 8'h20);
        bus_wr(19'h00000, 8'hA0);
        bus_wr(19'h20005, 8'h77);
        wait_ready(n);
        bus_wr(19'h00000, 8'hA0);
        bus_wr(19'h20006, 8'h11);
        wait_ready(n);
        expect_byte(19'h20005, 8'h77, "R5 fast program 1");
        expect_byte(19'h20006, 8'h11, "R5 fast program 2");
        bus_wr(19'h00000, 8'hF0);
        bus_wr(19'h00000, 8'hA0);
        bus_wr(19'h20007, 8'h22);
        check(ready == 1'b1, "R5 no program after exit", ready, 1);
        expect_byte(19'h20007, 8'hFF, "R5 exit blocks short form");
    endtask

    task automatic t_abort();
        bus_wr(19'h00555, 8'hAA);
        bus_wr(19'h00123, 8'h55);
        bus_wr(19'h00555, 8'hA0);
        bus_wr(19'h20008, 8'h00);
        check(ready == 1'b1, "R6 broken unlock idle", ready, 1);
        expect_byte(19'h20008, 8'hFF, "R6 broken unlock no write");
        unlock();
        bus_wr(19'h00555, 8'h77);
        bus_wr(19'h20009, 8'h00);
        expect_byte(19'h20009, 8'hFF, "R6 bad command no write");
    endtask

    task automatic t_sector_erase();
        int n;
        logic [7:0] s;
        prog(19'h04001, 8'h12); wait_ready(n);
        prog(19'h03FFF, 8'h34); wait_ready(n);
        prog(19'h06000, 8'h56); wait_ready(n);
        erase_seq(19'h05000, 8'h30);
        check(ready == 1'b0, "R7 busy on erase", ready, 0);
        bus_rd(19'h05000, s);
        check(s[7] == 1'b0, "R7 erase status bit 7", s[7], 0);
        wait_ready(n);
        check(n < WAIT_MAX, "R7 erase finishes", n, 0);
        expect_byte(19'h04001, 8'hFF, "R7 sector erased");
        expect_byte(19'h03FFF, 8'h34, "R13 lower neighbour kept");
        expect_byte(19'h06000, 8'h56, "R13 upper neighbour kept");
    endtask

    task automatic t_multi();
        int n;
        prog(19'h08000, 8'h01); wait_ready(n);
        prog(19'h40000, 8'h02); wait_ready(n);
        prog(19'h50000, 8'h03); wait_ready(n);
        erase_seq(19'h08000, 8'h30);
        bus_wr(19'h40000, 8'h30);
        wait_ready(n);
        expect_byte(19'h08000, 8'hFF, "R8 first sector erased");
        expect_byte(19'h40000, 8'hFF, "R8 added sector erased");
        expect_byte(19'h50000, 8'h03, "R8 other sector kept");
    endtask

    task automatic t_protect();
        int n;
        prot = 11'h100;
        prog(19'h50001, 8'h00);
        wait_ready(n);
        expect_byte(19'h50001, 8'hFF, "R10 protected program ignored");
        erase_seq(19'h50000, 8'h30);
        wait_ready(n);
        check(n < 200, "R10 protected erase completes", n, 0);
        expect_byte(19'h50000, 8'h03, "R10 protected erase ignored");
        prot = '0;
    endtask

    task automatic t_chip();
        int n;
        prot = 11'h001;
        erase_seq(19'h00555, 8'h10);
        check(ready == 1'b0, "R9 chip erase busy", ready, 0);
        wait_ready(n);
        check(n < WAIT_MAX, "R9 chip erase finishes", n, 0);
        expect_byte(19'h00012, 8'h50, "R9 protected sector kept");
        expect_byte(19'h10003, 8'hFF, "R9 sector 4 erased");
        expect_byte(19'h50000, 8'hFF, "R9 sector 8 erased");
        prot = '0;
    endtask

    task automatic t_suspend();
        int n;
        prog(19'h60004, 8'h44); wait_ready(n);
        erase_seq(19'h60000, 8'h30);
        repeat (ACCEPT_CYC + 3) @(negedge clk);
        bus_wr(19'h00000, 8'hB0);
        check(ready == 1'b1, "R11 ready after suspend", ready, 1);
        expect_byte(19'h60004, 8'h80, "R11 pending sector marker");
        expect_byte(19'h10003, 8'hFF, "R11 other sector readable");
        prog(19'h70001, 8'h99);
        wait_ready(n);
        expect_byte(19'h70001, 8'h99, "R11 program while suspended");
        bus_wr(19'h00000, 8'h30);
        check(ready == 1'b0, "R11 busy after resume", ready, 0);
        wait_ready(n);
        expect_byte(19'h60004, 8'hFF, "R11 erase completes");
        expect_byte(19'h70001, 8'h99, "R11 programmed byte kept");
    endtask

    task automatic t_hwreset();
        int n;
        erase_seq(19'h70000, 8'h30);
        repeat (ACCEPT_CYC + 20) @(negedge clk);
        hw_rst_n = 1'b0;
        @(negedge clk);
        hw_rst_n = 1'b1;
        check(ready == 1'b1, "R12 ready after abort", ready, 1);
        expect_byte(19'h00012, 8'h50, "R12 array kept");
        prog(19'h00013, 8'h0F);
        wait_ready(n);
        expect_byte(19'h00013, 8'h0F, "R12 decoder back in read mode");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_status();
        t_and();
        t_fast();
        t_abort();
        t_sector_erase();
        t_multi();
        t_protect();
        t_chip();
        t_suspend();
        t_hwreset();
        finish_run();
    end
endmodule